// File: doc/BRIEF.md
# Serial Memory Command Front-End

This block is the slave-side serial port of a page-organised flash memory. It watches the active-low chip select, decides at each select whether the host uses clock mode 0 or mode 3, and shifts in an 8-bit opcode MSB first on rising serial-clock edges. Two opcodes are answered locally. One returns a fixed four-byte identification string. The other returns a status byte that repeats for as long as the host keeps clocking. Every other opcode is passed on to downstream logic together with the 24-bit address that follows it. The serial output stays undriven for these opcodes.

The block samples its serial pins on a fast core clock, taken to be already synchronous to that clock. It reacts to the edges of the serial clock that it sees there. Output bits change on serial-clock falling edges, so the host can capture them on the next rising edge. A one-cycle request pulse marks every byte that the serializer starts sending. A busy input from the program/erase engine supplies the ready bit of the status byte.

Top module: `sfe_top`

## Requirements
- R1: While cs_n is high, so_oe is low in the same cycle, and output driving is cleared one cycle after any cycle in which cs_n is high.
- R2: After reset, mode3 is 1 and no instruction is accepted until cs_n has been seen high and then low. If cs_n is held low through the reset release, clocking an opcode produces no opcode_valid and no output drive.
- R3: On every cs_n high-to-low transition, mode3 takes the current sck level (0 selects mode 0, 1 selects mode 3) and keeps it until the next such transition.
- R4: While selected, si is shifted MSB first on each rising sck edge. One cycle after the 8th rising edge, opcode_valid pulses for one cycle and opcode holds the shifted value.
- R5: For opcode 9FH, output bits change only on falling sck edges. The first falling edge after the opcode presents bit 7 of the first byte. The bytes come out MSB first in the order 1FH, 27H, 01H, 00H.
- R6: After the fourth identification byte, so carries 00H for every further byte of the same selection.
- R7: For opcode D7H, the status byte is sent again and again. Its bit 7 is 1 when busy was low, and 0 when busy was high, at the falling edge that starts that byte. Bits 6:0 come from the STAT_FIXED parameter (default 2CH, so the bytes are ACH ready and 2CH busy).
- R8: For any other opcode, so_oe stays low for the whole selection. The next 24 rising edges shift si MSB first into the address, and one cycle after the 24th rising edge addr_valid pulses and addr holds that value.
- R9: byte_req pulses for one cycle each time the serializer loads a new output byte, which is exactly one cycle after the falling sck edge that starts it.
- R10: sck and si activity while cs_n is high changes neither opcode nor addr and produces no valid pulse. Raising cs_n in the middle of an opcode abandons it, and the next selection starts a fresh opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock as sampled on clk |
| si | input | 1 | Serial data in |
| busy | input | 1 | Internal program/erase in progress |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for the serial data pad |
| mode3 | output | 1 | Clock mode detected at the last select (1 = mode 3) |
| opcode | output | 8 | Last captured opcode |
| opcode_valid | output | 1 | One-cycle pulse when an opcode completes |
| addr | output | 24 | Last captured address |
| addr_valid | output | 1 | One-cycle pulse when an address completes |
| byte_req | output | 1 | One-cycle pulse per output byte loaded |

## Verification
Two events can land in the same cycle. One is the falling sck edge that loads a new status byte. The other is a change on busy, so the ready bit depends on which value is sampled at that load. The bench toggles busy in the gap between two status bytes, just before the falling edge that starts the next byte. A behavioural model, updated on every clock, predicts the ready bit from busy at that edge. Every cycle, the bench compares that prediction with so and byte_req. A second such collision is chip select rising mid-opcode while sck still moves, and it is judged by a fresh frame decoding correctly.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    localparam int OPC_W  = 8;
    localparam int ID_LEN = 4;

    localparam logic [OPC_W-1:0] OPC_IDENT  = 8'h9F;
    localparam logic [OPC_W-1:0] OPC_STATUS = 8'hD7;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPC,
        PH_ADDR,
        PH_IDENT,
        PH_STAT,
        PH_DONE
    } phase_e;

    // fixed identification string, MSB-first bytes in transmit order
    function automatic logic [7:0] ident_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    ident_byte = 8'h1F;
            3'd1:    ident_byte = 8'h27;
            3'd2:    ident_byte = 8'h01;
            default: ident_byte = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/sfe_edge.sv
module sfe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    output logic frame_start,
    output logic sck_rise,
    output logic sck_fall,
    output logic mode3
);

    typedef struct packed {
        logic cs;
        logic sck;
        logic armed;
        logic mode3;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     active;

    // a select edge only counts after cs_n was seen high following reset
    assign frame_start = st_q.cs & ~cs_n;
    assign active      = st_q.armed & ~cs_n;
    assign sck_rise    = active & sck & ~st_q.sck;
    assign sck_fall    = active & ~sck & st_q.sck;
    assign mode3       = st_q.mode3;

    always_comb begin
        st_d     = st_q;
        st_d.cs  = cs_n;
        st_d.sck = sck;
        if (cs_n) begin
            st_d.armed = 1'b0;
        end else if (frame_start) begin
            st_d.armed = 1'b1;
            st_d.mode3 = sck;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cs    <= 1'b0;
            st_q.sck   <= 1'b1;
            st_q.armed <= 1'b0;
            st_q.mode3 <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_start) |-> $stable(st_q.mode3));

    // R10
    no_edge_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !(sck_rise || sck_fall));

endmodule

// File: rtl/sfe_cmd.sv
module sfe_cmd
    import sfe_pkg::*;
#(
    parameter int ADDR_BYTES = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_n,
    input  logic                   frame_start,
    input  logic                   sck_rise,
    input  logic                   si,
    output phase_e                 phase,
    output logic [OPC_W-1:0]       opcode,
    output logic                   opcode_valid,
    output logic [ADDR_BYTES*8-1:0] addr,
    output logic                   addr_valid
);

    localparam int ADDR_BITS = ADDR_BYTES * 8;
    localparam int CW        = $clog2(ADDR_BITS + 1);

    typedef struct packed {
        phase_e                 phase;
        logic [CW-1:0]          cnt;
        logic [OPC_W-1:0]       opc_sr;
        logic [ADDR_BITS-1:0]   adr_sr;
        logic [OPC_W-1:0]       opc;
        logic [ADDR_BITS-1:0]   adr;
        logic                   opv;
        logic                   adv;
    } cmd_st_t;

    cmd_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.opv = 1'b0;
        st_d.adv = 1'b0;
        if (cs_n) begin
            st_d.phase = PH_IDLE;
            st_d.cnt   = '0;
        end else if (frame_start) begin
            st_d.phase  = PH_OPC;
            st_d.cnt    = '0;
            st_d.opc_sr = '0;
            st_d.adr_sr = '0;
        end else if (sck_rise) begin
            case (st_q.phase)
                PH_OPC: begin
                    st_d.opc_sr = {st_q.opc_sr[OPC_W-2:0], si};
                    if (st_q.cnt == CW'(OPC_W - 1)) begin
                        st_d.opc = st_d.opc_sr;
                        st_d.opv = 1'b1;
                        st_d.cnt = '0;
                        if (st_d.opc_sr == OPC_IDENT) begin
                            st_d.phase = PH_IDENT;
                        end else if (st_d.opc_sr == OPC_STATUS) begin
                            st_d.phase = PH_STAT;
                        end else begin
                            st_d.phase = PH_ADDR;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                PH_ADDR: begin
                    st_d.adr_sr = {st_q.adr_sr[ADDR_BITS-2:0], si};
                    if (st_q.cnt == CW'(ADDR_BITS - 1)) begin
                        st_d.adr   = st_d.adr_sr;
                        st_d.adv   = 1'b1;
                        st_d.cnt   = '0;
                        st_d.phase = PH_DONE;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase  <= PH_IDLE;
            st_q.cnt    <= '0;
            st_q.opc_sr <= '0;
            st_q.adr_sr <= '0;
            st_q.opc    <= '0;
            st_q.adr    <= '0;
            st_q.opv    <= 1'b0;
            st_q.adv    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase        = st_q.phase;
    assign opcode       = st_q.opc;
    assign opcode_valid = st_q.opv;
    assign addr         = st_q.adr;
    assign addr_valid   = st_q.adv;

    // R4
    opc_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.opv |-> $past(sck_rise));

    // R8
    adr_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.adv |-> $past(sck_rise));

    // R4
    valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_q.opv, st_q.adv}));

endmodule

// File: rtl/sfe_resp.sv
module sfe_resp
    import sfe_pkg::*;
#(
    parameter logic [6:0] STAT_FIXED = 7'h2C
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cs_n,
    input  logic   frame_start,
    input  logic   sck_fall,
    input  phase_e phase,
    input  logic   busy,
    output logic   so,
    output logic   drive,
    output logic   byte_req
);

    typedef struct packed {
        logic       so;
        logic [6:0] sr;
        logic [2:0] obits;
        logic [2:0] idx;
        logic       drive;
        logic       breq;
    } resp_st_t;

    resp_st_t   st_d, st_q;
    logic       talking;
    logic [7:0] nxt_byte;

    assign talking = (phase == PH_IDENT) || (phase == PH_STAT);

    always_comb begin
        if (phase == PH_IDENT) begin
            nxt_byte = (st_q.idx < 3'(ID_LEN)) ? ident_byte(st_q.idx) : 8'h00;
        end else begin
            nxt_byte = {~busy, STAT_FIXED};
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.breq = 1'b0;
        if (cs_n) begin
            st_d.drive = 1'b0;
        end else if (frame_start) begin
            st_d.obits = '0;
            st_d.idx   = '0;
            st_d.drive = 1'b0;
        end else if (sck_fall && talking) begin
            if (st_q.obits == 3'd0) begin
                st_d.so    = nxt_byte[7];
                st_d.sr    = nxt_byte[6:0];
                st_d.obits = 3'd7;
                st_d.drive = 1'b1;
                st_d.breq  = 1'b1;
                if (st_q.idx < 3'(ID_LEN)) begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end else begin
                st_d.so    = st_q.sr[6];
                st_d.sr    = {st_q.sr[5:0], 1'b0};
                st_d.obits = st_q.obits - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.so    <= 1'b0;
            st_q.sr    <= '0;
            st_q.obits <= '0;
            st_q.idx   <= '0;
            st_q.drive <= 1'b0;
            st_q.breq  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign so       = st_q.so;
    assign drive    = st_q.drive;
    assign byte_req = st_q.breq;

    // R9
    req_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.breq |-> $past(sck_fall));

    // R1
    drop_on_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !st_q.drive);

    // R8
    drive_needs_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.drive && !cs_n) |-> talking);

endmodule

// File: rtl/sfe_top.sv
module sfe_top
    import sfe_pkg::*;
#(
    parameter int         ADDR_BYTES = 3,
    parameter logic [6:0] STAT_FIXED = 7'h2C
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n,
    input  logic                    sck,
    input  logic                    si,
    input  logic                    busy,
    output logic                    so,
    output logic                    so_oe,
    output logic                    mode3,
    output logic [OPC_W-1:0]        opcode,
    output logic                    opcode_valid,
    output logic [ADDR_BYTES*8-1:0] addr,
    output logic                    addr_valid,
    output logic                    byte_req
);

    logic   frame_start;
    logic   sck_rise;
    logic   sck_fall;
    logic   drive;
    phase_e phase;

    sfe_edge u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .sck         (sck),
        .frame_start (frame_start),
        .sck_rise    (sck_rise),
        .sck_fall    (sck_fall),
        .mode3       (mode3)
    );

    sfe_cmd #(
        .ADDR_BYTES (ADDR_BYTES)
    ) u_cmd (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n         (cs_n),
        .frame_start  (frame_start),
        .sck_rise     (sck_rise),
        .si           (si),
        .phase        (phase),
        .opcode       (opcode),
        .opcode_valid (opcode_valid),
        .addr         (addr),
        .addr_valid   (addr_valid)
    );

    sfe_resp #(
        .STAT_FIXED (STAT_FIXED)
    ) u_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .frame_start (frame_start),
        .sck_fall    (sck_fall),
        .phase       (phase),
        .busy        (busy),
        .so          (so),
        .drive       (drive),
        .byte_req    (byte_req)
    );

    assign so_oe = drive & ~cs_n;

    // R8
    addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> !drive);

    // R4
    reply_after_opc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_req |-> !opcode_valid);

endmodule

// File: tb/sim_sfe_top.sv
module sim_sfe_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sck = 1'b1;
    logic        si = 1'b0;
    logic        busy = 1'b0;
    logic        so, so_oe, mode3, opcode_valid, addr_valid, byte_req;
    logic [7:0]  opcode;
    logic [23:0] addr;

    int checks = 0;
    int errors = 0;
    int opv_seen = 0;
    bit oe_seen = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sfe_top u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .busy(busy),
        .so(so), .so_oe(so_oe), .mode3(mode3), .opcode(opcode),
        .opcode_valid(opcode_valid), .addr(addr), .addr_valid(addr_valid),
        .byte_req(byte_req)
    );

    // ---------------- behavioural reference ----------------
    localparam int M_IDLE = 0, M_OPC = 1, M_ADR = 2, M_ID = 3, M_ST = 4, M_DONE = 5;
    logic [7:0] id_q[$] = '{8'h1F, 8'h27, 8'h01, 8'h00};
    bit   m_pcs, m_psck, m_armed, m_mode3, m_drive, m_so, m_opv, m_adv, m_breq;
    int   m_phase, m_cnt, m_idx, m_obits;
    int unsigned m_in, m_a, m_opc, m_addr;
    logic [7:0] m_cur;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pcs = 0; m_psck = 1; m_armed = 0; m_mode3 = 1; m_drive = 0; m_so = 0;
            m_opv = 0; m_adv = 0; m_breq = 0; m_phase = M_IDLE; m_cnt = 0;
            m_idx = 0; m_obits = 0; m_in = 0; m_a = 0; m_opc = 0; m_addr = 0; m_cur = 0;
        end else begin
            bit fcs, act, rise, fall;
            fcs  = m_pcs && !cs_n;
            act  = m_armed && !cs_n;
            rise = act && sck && !m_psck;
            fall = act && !sck && m_psck;
            m_opv = 0; m_adv = 0; m_breq = 0;
            if (cs_n) begin
                m_armed = 0; m_phase = M_IDLE; m_drive = 0; m_cnt = 0;
            end else if (fcs) begin
                m_armed = 1; m_mode3 = sck; m_phase = M_OPC; m_cnt = 0;
                m_drive = 0; m_idx = 0; m_obits = 0; m_in = 0; m_a = 0;
            end else begin
                if (rise && m_phase == M_OPC) begin
                    m_in = ((m_in << 1) | si) & 32'hFF; m_cnt++;
                    if (m_cnt == 8) begin
                        m_opc = m_in; m_opv = 1; m_cnt = 0;
                        m_phase = (m_in == 32'h9F) ? M_ID : (m_in == 32'hD7) ? M_ST : M_ADR;
                    end
                end else if (rise && m_phase == M_ADR) begin
                    m_a = ((m_a << 1) | si) & 32'hFFFFFF; m_cnt++;
                    if (m_cnt == 24) begin
                        m_addr = m_a; m_adv = 1; m_cnt = 0; m_phase = M_DONE;
                    end
                end
                if (fall && (m_phase == M_ID || m_phase == M_ST)) begin
                    if (m_obits == 0) begin
                        if (m_phase == M_ID) m_cur = (m_idx < 4) ? id_q[m_idx] : 8'h00;
                        else                 m_cur = {~busy, 7'h2C};
                        m_idx++;
                        m_so = m_cur[7]; m_obits = 7; m_drive = 1; m_breq = 1;
                    end else begin
                        m_so = m_cur[m_obits-1]; m_obits--;
                    end
                end
            end
            m_pcs = cs_n; m_psck = sck;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act_v, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act_v, exp_v);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit eoe;
            eoe = !cs_n && m_drive;
            check(so_oe === eoe, "R1", "so_oe", int'(so_oe), int'(eoe));
            if (eoe) check(so === m_so, (m_phase == M_ST) ? "R7" : "R5", "so", int'(so), int'(m_so));
            check(mode3 === m_mode3, "R3", "mode3", int'(mode3), int'(m_mode3));
            check(opcode_valid === m_opv, "R4", "opcode_valid", int'(opcode_valid), int'(m_opv));
            check(opcode === m_opc[7:0], "R4", "opcode", int'(opcode), int'(m_opc));
            check(addr_valid === m_adv, "R8", "addr_valid", int'(addr_valid), int'(m_adv));
            check(addr === m_addr[23:0], "R8", "addr", int'(addr), int'(m_addr));
            check(byte_req === m_breq, "R9", "byte_req", int'(byte_req), int'(m_breq));
            if (opcode_valid) opv_seen++;
            if (so_oe) oe_seen = 1;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic xfer(input logic [7:0] d, output logic [7:0] q);
        q = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0; si = d[i];
            cyc(2);
            sck = 1'b1;
            q[i] = so;
            cyc(2);
        end
    endtask

    task automatic begin_frame(input bit idle_high);
        cs_n = 1'b1; sck = idle_high;
        cyc(3);
        cs_n = 1'b0;
        cyc(2);
    endtask

    task automatic end_frame();
        sck = 1'b1;
        cyc(2);
        cs_n = 1'b1;
        cyc(3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        int snap;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        // R2 reset state
        check(mode3 === 1'b1 && so_oe === 1'b0 && opcode === 8'h00,
              "R2", "reset state", int'({mode3, so_oe}), 2);

        // R5 R6: identification in mode 0
        begin_frame(1'b0);
        check(mode3 === 1'b0, "R3", "mode0 select", int'(mode3), 0);
        xfer(8'h9F, r);
        check(opcode === 8'h9F, "R4", "opcode 9F", int'(opcode), 8'h9F);
        for (int b = 0; b < 6; b++) begin
            xfer(8'h00, r);
            check(r === ((b < 4) ? id_q[b] : 8'h00), (b < 4) ? "R5" : "R6",
                  "ident byte", int'(r), int'((b < 4) ? id_q[b] : 8'h00));
        end
        end_frame();
        check(so_oe === 1'b0, "R1", "oe after deselect", int'(so_oe), 0);

        // R3: identification in mode 3
        begin_frame(1'b1);
        check(mode3 === 1'b1, "R3", "mode3 select", int'(mode3), 1);
        xfer(8'h9F, r);
        for (int b = 0; b < 4; b++) begin
            xfer(8'h00, r);
            check(r === id_q[b], "R5", "ident byte mode3", int'(r), int'(id_q[b]));
        end
        end_frame();

        // R7: status repeated, busy flipped between bytes
        begin_frame(1'b0);
        xfer(8'hD7, r);
        busy = 1'b0; xfer(8'h00, r);
        check(r === 8'hAC, "R7", "status ready", int'(r), 8'hAC);
        busy = 1'b1; xfer(8'h00, r);
        check(r === 8'h2C, "R7", "status busy", int'(r), 8'h2C);
        busy = 1'b0; xfer(8'h00, r);
        check(r === 8'hAC, "R7", "status ready again", int'(r), 8'hAC);
        end_frame();

        // R8: other opcode, address captured, no drive
        oe_seen = 0;
        begin_frame(1'b1);
        xfer(8'h0B, r); xfer(8'h12, r); xfer(8'h34, r); xfer(8'h56, r);
        xfer(8'hFF, r);
        end_frame();
        check(addr === 24'h123456, "R8", "address", int'(addr), 24'h123456);
        check(oe_seen == 0, "R8", "no drive", int'(oe_seen), 0);

        // R10: activity while deselected ignored
        snap = opv_seen;
        for (int i = 0; i < 16; i++) begin
            sck = 1'b0; si = i[0]; cyc(2); sck = 1'b1; cyc(2);
        end
        check(opcode === 8'h0B && addr === 24'h123456 && opv_seen == snap,
              "R10", "deselected", int'(opcode), 8'h0B);

        // R10: abort mid-opcode, then fresh frame
        begin_frame(1'b0);
        for (int i = 0; i < 4; i++) begin
            sck = 1'b0; si = 1'b1; cyc(2); sck = 1'b1; cyc(2);
        end
        end_frame();
        check(opcode === 8'h0B, "R10", "abort keeps opcode", int'(opcode), 8'h0B);
        begin_frame(1'b0);
        xfer(8'hD7, r);
        xfer(8'h00, r);
        check(opcode === 8'hD7 && r === 8'hAC, "R10", "fresh frame", int'(r), 8'hAC);
        end_frame();

        // R2: select held low through reset, no instruction accepted
        cs_n = 1'b0; sck = 1'b0;
        cyc(1);
        rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(2);
        snap = opv_seen; oe_seen = 0;
        xfer(8'h9F, r); xfer(8'h00, r);
        check(opv_seen == snap && oe_seen == 0, "R2", "no fresh select", opv_seen - snap, 0);
        end_frame();
        begin_frame(1'b0);
        xfer(8'h9F, r); xfer(8'h00, r);
        check(r === 8'h1F, "R2", "accepted after fresh select", int'(r), 8'h1F);
        end_frame();

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule